// File: doc/BRIEF.md
# Clamped-Length Vector Loop Sequencer

This block walks a byte array on behalf of a vector loop whose size does not need to be a multiple of the hardware vector width. A one-cycle start strobe loads a base address and a byte count. The block then offers a sequence of steps on a valid/ready interface to a downstream vector load or store port. Each step carries an effective address, an active byte length and a per-byte enable mask. The block does not touch memory, move data or compute on vector data.

A single signed remaining-count register does three jobs. It is the loop counter. It is the negative offset from an end pointer, which is captured once at start as base plus size. It is also the requested length, which is clamped to the parameter `MAXVL`. Each accepted step subtracts `MAXVL` from the count. The loop stops when the count is no longer positive, so the last step covers only the leftover bytes and needs no separate tail logic. Any legal `MAXVL` runs the same loop without change.

Top module: `vlen_loop_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `step_valid_o` and `done_o` are both low.
- R2: A start received while no loop is active, with a nonzero size, makes `step_valid_o` high in the next cycle. That first step addresses the base.
- R3: Every offered step has address = (base + size − remaining) modulo 2^ADDR_W. Here remaining is the byte count still to be covered, so consecutive accepted steps advance the address by `MAXVL`.
- R4: `step_len_o` equals the remaining count when that count is below `MAXVL`, and equals `MAXVL` otherwise. It is never zero while valid.
- R5: Bit i of `step_mask_o` is 1 exactly when i < `step_len_o`. Bit 0 is the byte at the step address.
- R6: Each accepted step lowers the remaining count by `MAXVL`. A loop of size S gives exactly ceil(S / MAXVL) accepted steps, and the last one has length S − (steps − 1)·MAXVL.
- R7: While `step_valid_o` is high and `step_ready_i` is low, the valid signal, address, length and mask hold their values into the next cycle.
- R8: `done_o` is high for exactly the one cycle after the final step is accepted. `step_valid_o` is low in that cycle.
- R9: A start with size zero offers no step and raises `done_o` in the next cycle.
- R10: A start received while a loop is active, including in the cycle its final step is accepted, is ignored.
- R11: A start received in the cycle where `done_o` is high is accepted and begins a new loop in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new loop |
| base_i | input | ADDR_W | Array base byte address |
| size_i | input | CNT_W | Array size in bytes |
| step_valid_o | output | 1 | A step is offered |
| step_ready_i | input | 1 | Downstream accepts the offered step |
| step_addr_o | output | ADDR_W | Effective byte address of the step |
| step_len_o | output | LEN_W | Active byte count of the step |
| step_mask_o | output | MAXVL | Per-byte enable, lowest bits active |
| done_o | output | 1 | One-cycle pulse at loop end |

## Verification
Two functions can land in the same cycle. One is the completion pulse of a loop. The other is the start strobe for the next loop. The bench issues each new loop's start in the very cycle it sees `done_o`, and expects a fresh first step one cycle later. It also asserts start together with `ready` on the final step of a loop. That start must be dropped: the done cycle must show no valid, and the next loop's addresses must follow only its own base. Randomized ready gaps also put stalls right before the short final step, so the hold rule is tested on a partial mask.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/vls_len_clamp.sv
module vls_len_clamp #(
    parameter int CNT_W = 20,
    parameter int MAXVL = 16,
    parameter int LEN_W = $clog2(MAXVL + 1)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [LEN_W-1:0] len_o,
    output logic [MAXVL-1:0] mask_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAXVL);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAXVL);

    // saturate the requested byte count at the vector width
    always_comb begin
        if (cnt_i >= MAX_CNT) begin
            len_o = MAX_LEN;
        end else begin
            len_o = cnt_i[LEN_W-1:0];
        end
    end

    // thermometer mask: one lane per byte below the clamped length
    for (genvar g = 0; g < MAXVL; g++) begin : g_lane
        assign mask_o[g] = (LEN_W'(g) < len_o);
    end

endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 20
) (
    input  logic [ADDR_W-1:0] end_ptr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] addr_o
);

    // effective address = end pointer minus bytes still to go
    assign addr_o = end_ptr_i - ADDR_W'(cnt_i);

endmodule

// File: rtl/vlen_loop_seq.sv
module vlen_loop_seq #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 20,
    parameter int MAXVL  = 16,
    parameter int LEN_W  = $clog2(MAXVL + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  size_i,
    output logic              step_valid_o,
    input  logic              step_ready_i,
    output logic [ADDR_W-1:0] step_addr_o,
    output logic [LEN_W-1:0]  step_len_o,
    output logic [MAXVL-1:0]  step_mask_o,
    output logic              done_o
);

    import vls_pkg::*;

    // one extra bit so that stepping past zero goes negative, not around
    localparam int REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] STRIDE = REM_W'(MAXVL);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] end_ptr;
        logic [REM_W-1:0]  rem;
        logic              done;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic [REM_W-1:0] rem_after;

    assign rem_after = cur_q.rem - STRIDE;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    nxt_d.end_ptr = base_i + ADDR_W'(size_i);
                    nxt_d.rem     = {1'b0, size_i};
                    if (size_i == '0) begin
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.state = SEQ_RUN;
                    end
                end
            end
            SEQ_RUN: begin
                if (step_ready_i) begin
                    nxt_d.rem = rem_after;
                    if ($signed(rem_after) <= 0) begin
                        nxt_d.state = SEQ_IDLE;
                        nxt_d.done  = 1'b1;
                    end
                end
            end
            default: nxt_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{state: SEQ_IDLE, end_ptr: '0, rem: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    vls_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) i_addr_gen (
        .end_ptr_i (cur_q.end_ptr),
        .cnt_i     (cur_q.rem[CNT_W-1:0]),
        .addr_o    (step_addr_o)
    );

    vls_len_clamp #(
        .CNT_W (CNT_W),
        .MAXVL (MAXVL),
        .LEN_W (LEN_W)
    ) i_len_clamp (
        .cnt_i  (cur_q.rem[CNT_W-1:0]),
        .len_o  (step_len_o),
        .mask_o (step_mask_o)
    );

    assign step_valid_o = (cur_q.state == SEQ_RUN);
    assign done_o       = cur_q.done;

endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
    parameter int ADDR_W = 32,
    parameter int MAXVL  = 16,
    parameter int LEN_W  = $clog2(MAXVL + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              step_valid_o,
    input logic              step_ready_i,
    input logic [ADDR_W-1:0] step_addr_o,
    input logic [LEN_W-1:0]  step_len_o,
    input logic [MAXVL-1:0]  step_mask_o,
    input logic              done_o
);

    // consecutive accepted steps of one loop are MAXVL bytes apart
    p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_valid_o && step_ready_i |=> !step_valid_o
            || step_addr_o == $past(step_addr_o) + ADDR_W'(MAXVL));

    p_len_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_valid_o |-> step_len_o != '0 && step_len_o <= LEN_W'(MAXVL));

    p_mask_thermo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_valid_o |-> $countones(step_mask_o) == 32'(step_len_o)
            && ((step_mask_o + MAXVL'(1)) & step_mask_o) == '0);

    // a short step can only be the last one
    p_short_is_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_valid_o && step_ready_i && step_len_o < LEN_W'(MAXVL) |=> done_o);

    p_hold_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_valid_o && !step_ready_i |=> step_valid_o && $stable(step_addr_o)
            && $stable(step_len_o) && $stable(step_mask_o));

    p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !step_valid_o);

endmodule

bind vlen_loop_seq vls_checker #(
    .ADDR_W (ADDR_W),
    .MAXVL  (MAXVL),
    .LEN_W  (LEN_W)
) i_vls_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_valid_o (step_valid_o),
    .step_ready_i (step_ready_i),
    .step_addr_o  (step_addr_o),
    .step_len_o   (step_len_o),
    .step_mask_o  (step_mask_o),
    .done_o       (done_o)
);

// File: tb/test_vlen_loop_seq.sv
module test_vlen_loop_seq;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 20;
    localparam int MAXVL  = 16;
    localparam int LEN_W  = $clog2(MAXVL + 1);

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [CNT_W-1:0]  size_i = '0;
    logic              step_valid_o;
    logic              step_ready_i = 1'b0;
    logic [ADDR_W-1:0] step_addr_o;
    logic [LEN_W-1:0]  step_len_o;
    logic [MAXVL-1:0]  step_mask_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;

    vlen_loop_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .MAXVL  (MAXVL)
    ) i_vlen_loop_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .base_i       (base_i),
        .size_i       (size_i),
        .step_valid_o (step_valid_o),
        .step_ready_i (step_ready_i),
        .step_addr_o  (step_addr_o),
        .step_len_o   (step_len_o),
        .step_mask_o  (step_mask_o),
        .done_o       (done_o)
    );

    function automatic int exp_len(input int rem);
        return (rem >= MAXVL) ? MAXVL : rem;
    endfunction

    function automatic logic [MAXVL-1:0] exp_mask(input int len);
        logic [MAXVL-1:0] m = '0;
        for (int i = 0; i < MAXVL; i++) m[i] = (i < len);
        return m;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; raises start there. Returns at the falling
    // edge where done is expected, so the next call starts in that cycle.
    task automatic run_loop(input logic [ADDR_W-1:0] base, input int size,
                            input int ready_pct, input bit poke);
        logic [ADDR_W-1:0] endp = base + ADDR_W'(size);
        int rem = size;
        int steps = 0;
        bit stalled = 1'b0;
        bit first = 1'b1;
        logic [ADDR_W-1:0] p_addr = '0;
        logic [LEN_W-1:0]  p_len = '0;
        logic [MAXVL-1:0]  p_mask = '0;
        start_i = 1'b1;
        base_i  = base;
        size_i  = CNT_W'(size);
        @(negedge clk_i);
        start_i = 1'b0;
        if (size == 0) begin
            chk(done_o === 1'b1, "R9 done", 64'(done_o), 1);
            chk(step_valid_o === 1'b0, "R9 no step", 64'(step_valid_o), 0);
            return;
        end
        while (1) begin
            bit r;
            chk(step_valid_o === 1'b1, "R2 valid", 64'(step_valid_o), 1);
            if (first)
                chk(step_addr_o === base, "R2 first addr", 64'(step_addr_o), 64'(base));
            chk(step_addr_o === endp - ADDR_W'(rem), "R3 addr",
                64'(step_addr_o), 64'(endp - ADDR_W'(rem)));
            chk(step_len_o === LEN_W'(exp_len(rem)), "R4 len",
                64'(step_len_o), 64'(exp_len(rem)));
            chk(step_mask_o === exp_mask(exp_len(rem)), "R5 mask",
                64'(step_mask_o), 64'(exp_mask(exp_len(rem))));
            if (stalled)
                chk(step_addr_o === p_addr && step_len_o === p_len && step_mask_o === p_mask,
                    "R7 hold", 64'(step_addr_o), 64'(p_addr));
            first  = 1'b0;
            p_addr = step_addr_o;
            p_len  = step_len_o;
            p_mask = step_mask_o;
            r = ($urandom % 100) < ready_pct;
            step_ready_i = r;
            if (poke) begin
                start_i = 1'b1;
                base_i  = ~base;
                size_i  = CNT_W'(3);
            end
            @(negedge clk_i);
            step_ready_i = 1'b0;
            start_i = 1'b0;
            stalled = !r;
            if (r) begin
                rem -= MAXVL;
                steps++;
                if (rem <= 0) begin
                    chk(done_o === 1'b1, "R8 done pulse", 64'(done_o), 1);
                    chk(step_valid_o === 1'b0, "R8/R10 idle at done", 64'(step_valid_o), 0);
                    chk(steps == (size + MAXVL - 1) / MAXVL, "R6 step count",
                        64'(steps), 64'((size + MAXVL - 1) / MAXVL));
                    return;
                end
            end
        end
    endtask

    task automatic idle_gap();
        @(negedge clk_i);
        chk(done_o === 1'b0, "R8 single cycle", 64'(done_o), 0);
        chk(step_valid_o === 1'b0, "R8 stays idle", 64'(step_valid_o), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk_i);
        chk(step_valid_o === 1'b0 && done_o === 1'b0, "R1 in reset",
            64'({step_valid_o, done_o}), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(step_valid_o === 1'b0 && done_o === 1'b0, "R1 after reset",
            64'({step_valid_o, done_o}), 0);

        // directed sizes around the vector width; R11 back-to-back starts
        run_loop(32'h0000_1000, 1, 100, 1'b0);
        run_loop(32'h0000_2000, MAXVL - 1, 100, 1'b0);
        run_loop(32'h0000_3000, MAXVL, 100, 1'b0);
        run_loop(32'h0000_4000, MAXVL + 1, 60, 1'b0);
        idle_gap();
        run_loop(32'h0000_5000, 0, 100, 1'b0);
        run_loop(32'h0000_6000, 2 * MAXVL + 1, 50, 1'b0);
        run_loop(32'hFFFF_FFF0, 3 * MAXVL + 5, 70, 1'b0);
        // R10: start held high throughout an active loop
        run_loop(32'h0000_7000, 4 * MAXVL + 3, 50, 1'b1);
        run_loop(32'h0000_8000, 0, 100, 1'b0);
        run_loop(32'h0000_9000, 2, 100, 1'b0);
        idle_gap();

        for (int n = 0; n < 60; n++) begin
            int sz;
            sz = (n % 7 == 0) ? 0 : $urandom_range(1, 300);
            run_loop($urandom, sz, $urandom_range(30, 100), ($urandom % 4) == 0);
            if ($urandom % 2) idle_gap();
        end
        idle_gap();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule